// File: doc/BRIEF.md
# Multicycle Control Step Sequencer

This block produces the numbered time steps that a bus-based multicycle processor control unit uses to order its control signals. A 4-bit step counter feeds a decoder whose outputs are one-hot step lines, T0 up to T15. The first three steps (T0 to T2) are the fetch steps that every instruction shares. After them, the step number, the opcode and a few data path conditions choose the control signals. Those equations sit outside this block.

The counter moves forward by one on each master clock edge while stepping is enabled. It has two load paths. An end-of-instruction input returns it to T0 so that the next fetch starts. A jump input loads a fixed step number, so that a step can repeat as a loop. Stepping is gated by a run state machine and by a memory handshake. While the current step asks to wait, the counter holds until the memory's completion signal has passed through a synchronizing flip-flop. Read and write requests are captured in holding flip-flops that drive the memory. The synchronized completion signal releases them.

The run state machine has two states, `RUN_HALT` and `RUN_GO`. It has these transitions:
- `RUN_HALT` goes to `RUN_GO` when start is high.
- `RUN_GO` goes to `RUN_HALT` when stop is high.
- With both inputs high, it toggles.
- Reset forces `RUN_HALT`.

Top module: `step_sequencer`

## Requirements
- R1: A synchronous reset forces the step counter to 0, the run state to halted and both memory request outputs to 0. Reset takes priority over every other input.
- R2: While running, exactly one step line is high, bit k of `step_lines` for counter value k.
- R3: On each enabled clock edge with neither end nor jump asserted, the counter increases by one, wrapping from 15 to 0. Stepping is enabled when the run state is running and either `wait_req` is low or the synchronized completion flag is set.
- R4: While `wait_req` is high, the step holds. A `mem_done` pulse is registered into the synchronized completion flag on the next edge, and the step advances on the edge after that.
- R5: `instr_end` on an enabled edge loads step 0.
- R6: `jump` on an enabled edge loads step `GOTO_STEP` (default 6). Repeated jumps keep the counter at that step.
- R7: When `instr_end` and `jump` are both high on an enabled edge, the counter loads 0.
- R8: `start` moves `RUN_HALT` to `RUN_GO` and `stop` moves `RUN_GO` to `RUN_HALT`; both together toggle the state. Enable uses the registered run state, so:
  - the edge that starts running takes no step;
  - the edge that stops running still takes one step.
- R9: While halted, the counter holds and `instr_end` and `jump` have no effect. Step lines T1 to T15 are low, and T0 is high only when the counter is 0.
- R10: `rd_req` (`wr_req`) sets `mem_rd` (`mem_wr`) on the next edge. Each output stays high until the edge after the synchronized completion flag is seen set. A new request on that same edge keeps the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run start request (J side of run state) |
| stop | input | 1 | Run stop request (K side of run state) |
| instr_end | input | 1 | End of instruction: next step is T0 |
| jump | input | 1 | Load the fixed step `GOTO_STEP` instead of incrementing |
| wait_req | input | 1 | Current step waits for memory completion |
| mem_done | input | 1 | Asynchronous memory completion signal |
| rd_req | input | 1 | Memory read request from control logic |
| wr_req | input | 1 | Memory write request from control logic |
| step_lines | output | 16 | One-hot time step lines T0..T15 |
| mem_rd | output | 1 | Held read request to the memory |
| mem_wr | output | 1 | Held write request to the memory |

## Verification
The hardest situation to reach from the ports is the one-cycle gap between `mem_done` and the step advance during a wait. The stimulus holds `wait_req` for several cycles and pulses `mem_done` once. It then confirms that the step holds on the edge that captures the pulse and moves only on the following edge. A second awkward case is the edge where `start` and `stop` coincide: the run state toggles while the counter takes, or skips, a step based on the old state. The vector table walks into that edge from both the running and the halted state.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic {
        RUN_HALT = 1'b0,
        RUN_GO   = 1'b1
    } run_state_e;
endpackage

// File: rtl/seq_run_ctl.sv
module seq_run_ctl
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic wait_req,
    input  logic mem_done,
    output logic run_on,
    output logic sdone,
    output logic step_en
);
    run_state_e state_q, state_nx;
    logic       sdone_q;

    // state register and done synchronizer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RUN_HALT;
            sdone_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            sdone_q <= mem_done;
        end
    end

    // next state: J/K behaviour, both inputs toggle
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RUN_HALT: if (start) state_nx = RUN_GO;
            RUN_GO:   if (stop)  state_nx = RUN_HALT;
            default:  state_nx = RUN_HALT;
        endcase
    end

    // outputs
    always_comb begin
        run_on  = (state_q == RUN_GO);
        sdone   = sdone_q;
        step_en = run_on && (!wait_req || sdone_q);
    end
endmodule

// File: rtl/seq_step_cnt.sv
module seq_step_cnt #(
    parameter int CW        = 4,
    parameter int GOTO_STEP = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          instr_end,
    input  logic          jump,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] JUMP_V = CW'(GOTO_STEP);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step_en) begin
            if (instr_end)
                cnt_q <= '0;
            else if (jump)
                cnt_q <= JUMP_V;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/seq_step_dec.sv
module seq_step_dec #(
    parameter int CW = 4,
    parameter int NS = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic          run_on,
    output logic [NS-1:0] lines
);
    for (genvar i = 0; i < NS; i++) begin : g_line
        if (i == 0) begin : g_first
            assign lines[i] = (cnt == CW'(i));
        end else begin : g_rest
            assign lines[i] = run_on && (cnt == CW'(i));
        end
    end
endmodule

// File: rtl/seq_mem_req.sv
module seq_mem_req #(
    parameter int NREQ = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req,
    input  logic            sdone,
    output logic [NREQ-1:0] hold
);
    for (genvar k = 0; k < NREQ; k++) begin : g_req
        logic hold_q;
        always_ff @(posedge clk) begin
            if (rst)
                hold_q <= 1'b0;
            else if (req[k])
                hold_q <= 1'b1;
            else if (sdone)
                hold_q <= 1'b0;
        end
        assign hold[k] = hold_q;
    end
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer #(
    parameter int CNT_W     = 4,
    parameter int GOTO_STEP = 6,
    localparam int NSTEPS   = 1 << CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              instr_end,
    input  logic              jump,
    input  logic              wait_req,
    input  logic              mem_done,
    input  logic              rd_req,
    input  logic              wr_req,
    output logic [NSTEPS-1:0] step_lines,
    output logic              mem_rd,
    output logic              mem_wr
);
    logic             run_on;
    logic             sdone;
    logic             step_en;
    logic [CNT_W-1:0] step_cnt;
    logic [1:0]       req_hold;

    seq_run_ctl u_run (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .wait_req (wait_req),
        .mem_done (mem_done),
        .run_on   (run_on),
        .sdone    (sdone),
        .step_en  (step_en)
    );

    seq_step_cnt #(.CW(CNT_W), .GOTO_STEP(GOTO_STEP)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .instr_end (instr_end),
        .jump      (jump),
        .cnt       (step_cnt)
    );

    seq_step_dec #(.CW(CNT_W), .NS(NSTEPS)) u_dec (
        .cnt    (step_cnt),
        .run_on (run_on),
        .lines  (step_lines)
    );

    seq_mem_req #(.NREQ(2)) u_req (
        .clk   (clk),
        .rst   (rst),
        .req   ({wr_req, rd_req}),
        .sdone (sdone),
        .hold  (req_hold)
    );

    assign mem_rd = req_hold[0];
    assign mem_wr = req_hold[1];
endmodule

// File: rtl/step_sequencer_chk.sv
module step_sequencer_chk #(
    parameter int CW        = 4,
    parameter int NS        = 16,
    parameter int GOTO_STEP = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          instr_end,
    input logic          jump,
    input logic          wait_req,
    input logic          mem_done,
    input logic          rd_req,
    input logic [NS-1:0] step_lines,
    input logic          mem_rd,
    input logic          run_on,
    input logic          sdone,
    input logic [CW-1:0] step_cnt
);
    logic adv;
    assign adv = run_on && (!wait_req || sdone);

    // R2
    onehot_lines_chk: assert property (@(posedge clk) disable iff (rst)
        run_on |-> $onehot(step_lines));

    // R9
    halted_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !run_on |-> (step_lines[NS-1:1] == '0 && step_lines[0] == (step_cnt == '0)));

    // R9
    hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(step_cnt));

    // R3
    incr_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !instr_end && !jump) |=> step_cnt == CW'($past(step_cnt) + 1'b1));

    // R5
    end_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && instr_end) |=> step_cnt == '0);

    // R6
    goto_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && jump && !instr_end) |=> step_cnt == CW'(GOTO_STEP));

    // R4
    sync_chk: assert property (@(posedge clk) disable iff (rst)
        mem_done |=> sdone);

    // R10
    rd_set_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> mem_rd);

    // R10
    rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !sdone) |=> mem_rd);
endmodule

bind step_sequencer step_sequencer_chk #(
    .CW(CNT_W), .NS(NSTEPS), .GOTO_STEP(GOTO_STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_end  (instr_end),
    .jump       (jump),
    .wait_req   (wait_req),
    .mem_done   (mem_done),
    .rd_req     (rd_req),
    .step_lines (step_lines),
    .mem_rd     (mem_rd),
    .run_on     (run_on),
    .sdone      (sdone),
    .step_cnt   (step_cnt)
);

// File: tb/sim_step_sequencer.sv
`timescale 1ns/1ps
module sim_step_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 0, stop = 0, instr_end = 0, jump = 0;
    logic        wait_req = 0, mem_done = 0, rd_req = 0, wr_req = 0;
    logic [15:0] step_lines;
    logic        mem_rd, mem_wr;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    step_sequencer u0 (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .instr_end(instr_end), .jump(jump), .wait_req(wait_req),
        .mem_done(mem_done), .rd_req(rd_req), .wr_req(wr_req),
        .step_lines(step_lines), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    // {start,stop,end,jump,wait,done, idx[3:0], run, tag[3:0]}
    localparam logic [14:0] VEC [25] = '{
        15'b100000_0000_1_1000, 15'b000000_0001_1_0011,
        15'b000010_0001_1_0100, 15'b000010_0001_1_0100,
        15'b000011_0001_1_0100, 15'b000010_0010_1_0100,
        15'b000000_0011_1_0011, 15'b000000_0100_1_0011,
        15'b000000_0101_1_0011, 15'b001000_0000_1_0101,
        15'b000000_0001_1_0010, 15'b000000_0010_1_0010,
        15'b000000_0011_1_0010, 15'b000000_0100_1_0010,
        15'b000000_0101_1_0010, 15'b000100_0110_1_0110,
        15'b000100_0110_1_0110, 15'b000000_0111_1_0011,
        15'b001100_0000_1_0111, 15'b010000_0001_0_1000,
        15'b001100_0001_0_1001, 15'b100000_0001_1_1000,
        15'b110000_0010_0_1000, 15'b110000_0010_1_1000,
        15'b001000_0000_1_0101
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [15:0] exp_lines(input logic [3:0] idx, input logic run);
        if (run) return 16'd1 << idx;
        return (idx == 4'd0) ? 16'd1 : 16'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_in();
        start = 0; stop = 0; instr_end = 0; jump = 0;
        wait_req = 0; mem_done = 0; rd_req = 0; wr_req = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1", {16'd0, step_lines}, 32'd1);
        chk("R1", {mem_wr, mem_rd}, 32'd0);

        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            {start, stop, instr_end, jump, wait_req, mem_done} = VEC[i][14:9];
            tick();
            chk(tag_name(VEC[i][3:0]), {16'd0, step_lines},
                {16'd0, exp_lines(VEC[i][8:5], VEC[i][4])});
        end

        // R3 wrap from 15 back to 0
        @(negedge clk); clr_in();
        for (int i = 1; i <= 15; i++) tick();
        chk("R3", {16'd0, step_lines}, 32'h8000);
        tick();
        chk("R3", {16'd0, step_lines}, 32'd1);

        // R10 read request held until synchronized done
        @(negedge clk); rd_req = 1;
        tick();
        chk("R10", {31'd0, mem_rd}, 32'd1);
        @(negedge clk); rd_req = 0;
        tick(); tick();
        chk("R10", {31'd0, mem_rd}, 32'd1);
        @(negedge clk); mem_done = 1;
        tick();
        chk("R10", {31'd0, mem_rd}, 32'd1);
        @(negedge clk); mem_done = 0;
        tick();
        chk("R10", {31'd0, mem_rd}, 32'd0);

        // R10 write: request on the same edge as sdone keeps it set
        @(negedge clk); wr_req = 1;
        tick();
        chk("R10", {31'd0, mem_wr}, 32'd1);
        @(negedge clk); wr_req = 0; mem_done = 1;
        tick();
        @(negedge clk); mem_done = 0; wr_req = 1;
        tick();
        chk("R10", {31'd0, mem_wr}, 32'd1);
        @(negedge clk); wr_req = 0; mem_done = 1;
        tick();
        @(negedge clk); mem_done = 0;
        tick();
        chk("R10", {31'd0, mem_wr}, 32'd0);

        // R1 reset wins over jump and clears held request
        @(negedge clk); rd_req = 1; jump = 1;
        tick();
        @(negedge clk); rd_req = 0; rst = 1;
        tick();
        chk("R1", {15'd0, mem_rd, step_lines}, 32'd1);
        @(negedge clk); rst = 0; jump = 0;
        tick();
        chk("R1", {16'd0, step_lines}, 32'd1);

        finish_run();
    end
endmodule